// File: doc/BRIEF.md
# Timestamp Prescaler with Overflow Interrupt

This block keeps a free-running 16-bit timestamp that advances at a programmable fraction of the system clock rate. A 24-bit reload value sets how many system clocks pass between steps. When the timestamp wraps from its all-ones value back to zero, an overflow status bit is raised, the overflow is counted in a saturating tally of events that software has not yet serviced, and a one-cycle interrupt pulse is sent if the overflow interrupt is enabled.

Software reaches the block through a simple word-addressed register bus with a write strobe and a combinational read path. Software can set the raw status itself, clear it through a separate clear shadow, set and clear the interrupt enable through two separate registers, and read the enable back from a third. Each end-of-interrupt acknowledge takes one overflow off the tally. If more than one overflow was pending, the acknowledge sends a new pulse, so no overflow is lost while the handler runs.

Top module: `ts_ovf_regs`

## Requirements
- R1: After reset, every register reads 0, with one exception: the control register at word address 0x0 reads 0x8, because its bit 3 (debug-suspend-free) resets to 1. The timestamp output is 0 and the interrupt output is low.
- R2: While counting is enabled, the timestamp steps by one every N system clocks, where N is the reload value at word address 0x7 (bits 23:0). A reload of 0 gives the same behaviour as a reload of 1.
- R3: Counting is enabled by bit 6 of the control register. While that bit is 0, the timestamp and its prescaler hold their values.
- R4: When the timestamp wraps from 0xFFFF to 0x0000, bit 0 of the raw status register (word 0x1) is set.
- R5: A write with bit 0 = 1 to the raw status register sets that bit. A write with bit 0 = 0 has no effect.
- R6: A write with bit 0 = 1 to the status clear shadow (word 0x2) clears the raw status bit. Reads of the shadow always return 0.
- R7: The overflow interrupt enable is set by writing 1 to bit 0 of word 0x3 and cleared by writing 1 to bit 0 of word 0x4. Its state reads back from bit 0 of word 0x5. Reads of word 0x4 return 0.
- R8: The unserviced counter (word 0x8, bits 4:0) increases by one for each cycle in which the raw status bit is set, by hardware, by software or by both together. It saturates at 31.
- R9: A write of 0x00 to the end-of-interrupt register (word 0x6, bits 7:0) decreases the unserviced counter by one, but never below 0. If the counter was above 1 and the enable is set, the write sends a new interrupt pulse. Writes of any other value leave the counter unchanged.
- R10: The interrupt output is high for one cycle, in the cycle after a set event or a qualifying acknowledge, and only if the enable was set when that event occurred.
- R11: Reserved bits read 0. Only control bits 6:3 and reload bits 23:0 are stored. Unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address (combinational) |
| ts_value | output | 16 | Current timestamp |
| ts_irq | output | 1 | One-cycle overflow interrupt pulse |

## Verification
The properties assume the bus issues at most one write per cycle and that a write strobe is never held across reset release. Under these assumptions, a software set, a clear and an acknowledge cannot coincide from the bus side. Only a hardware wrap can coincide with a bus write. The stimulus drives single-cycle writes on the falling edge, with idle cycles between them, and waits out the internal reset synchroniser before the first access. A wrap that lands in the same cycle as a software set is left to the checker.

// File: rtl/ts_ovf_pkg.sv
package ts_ovf_pkg;

  localparam int ADDR_W = 4;
  localparam int DATA_W = 32;

  // word addresses
  localparam logic [ADDR_W-1:0] A_CTRL   = 4'h0;
  localparam logic [ADDR_W-1:0] A_RAW    = 4'h1;
  localparam logic [ADDR_W-1:0] A_RAWCLR = 4'h2;
  localparam logic [ADDR_W-1:0] A_ENSET  = 4'h3;
  localparam logic [ADDR_W-1:0] A_ENCLR  = 4'h4;
  localparam logic [ADDR_W-1:0] A_ENSTAT = 4'h5;
  localparam logic [ADDR_W-1:0] A_EOI    = 4'h6;
  localparam logic [ADDR_W-1:0] A_RELOAD = 4'h7;
  localparam logic [ADDR_W-1:0] A_PEND   = 4'h8;

  // control field layout: stored bits LO..HI
  localparam int CTRL_LO     = 3;
  localparam int CTRL_HI     = 6;
  localparam int CTRL_W      = CTRL_HI - CTRL_LO + 1;
  localparam int CTRL_RUN    = CTRL_HI - CTRL_LO;   // bit 6 within stored field
  localparam logic [CTRL_W-1:0] CTRL_RST = 4'b0001; // debug-free bit high

  localparam int EOI_W = 8;

  typedef struct packed {
    logic             wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } bus_req_t;

endpackage

// File: rtl/ts_counter.sv
module ts_counter #(
  parameter int TS_W     = 16,
  parameter int RELOAD_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                run,
  input  logic [RELOAD_W-1:0] reload,
  output logic [TS_W-1:0]     ts,
  output logic                wrap_evt
);

  logic [RELOAD_W-1:0] pre_q, pre_n;
  logic [TS_W-1:0]     ts_q, ts_n;
  logic [RELOAD_W-1:0] eff_reload;
  logic                at_limit;
  logic                tick;

  always_comb begin
    eff_reload = (reload == '0) ? RELOAD_W'(1) : reload;
    at_limit   = (pre_q >= (eff_reload - 1'b1));
    tick       = run && at_limit;
    pre_n      = at_limit ? '0 : (pre_q + 1'b1);
    ts_n       = tick ? (ts_q + 1'b1) : ts_q;
    wrap_evt   = tick && (ts_q == '1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ts_q  <= '0;
    end else if (run) begin
      pre_q <= pre_n;
      ts_q  <= ts_n;
    end
  end

  assign ts = ts_q;

endmodule

// File: rtl/ts_pend_tracker.sv
module ts_pend_tracker #(
  parameter int PEND_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_evt,
  input  logic              ack,
  input  logic              ovf_en,
  output logic [PEND_W-1:0] pend,
  output logic              irq
);

  localparam logic [PEND_W-1:0] PEND_MAX = '1;
  localparam logic [PEND_W-1:0] PEND_ONE = PEND_W'(1);

  logic [PEND_W-1:0] pend_q, pend_n;
  logic              irq_q, irq_n;
  logic              reissue;

  always_comb begin
    pend_n = pend_q;
    unique case ({set_evt, ack})
      2'b10: pend_n = (pend_q == PEND_MAX) ? pend_q : (pend_q + 1'b1);
      2'b01: pend_n = (pend_q == '0) ? pend_q : (pend_q - 1'b1);
      2'b11: pend_n = (pend_q == '0) ? PEND_ONE : pend_q;
      default: pend_n = pend_q;
    endcase
    reissue = ack && (pend_q > PEND_ONE);
    irq_n   = ovf_en && (set_evt || reissue);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      irq_q  <= irq_n;
    end
  end

  assign pend = pend_q;
  assign irq  = irq_q;

endmodule

// File: rtl/ts_regfile.sv
module ts_regfile
  import ts_ovf_pkg::*;
#(
  parameter int RELOAD_W = 24,
  parameter int PEND_W   = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  bus_req_t            req,
  output logic [DATA_W-1:0]   rdata,
  input  logic                hw_wrap,
  input  logic [PEND_W-1:0]   pend,
  output logic                run,
  output logic [RELOAD_W-1:0] reload,
  output logic                ovf_en,
  output logic                set_evt,
  output logic                ack
);

  logic [CTRL_W-1:0]   ctrl_q, ctrl_n;
  logic [RELOAD_W-1:0] reload_q, reload_n;
  logic                raw_q, raw_n;
  logic                en_q, en_n;

  logic wr_ctrl, wr_raw, wr_rawclr, wr_enset, wr_enclr, wr_eoi, wr_reload;
  logic sw_set, sw_clr, en_set, en_clr;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^req.wdata[DATA_W-1:RELOAD_W];

  // write decode
  always_comb begin
    wr_ctrl   = req.wr && (req.addr == A_CTRL);
    wr_raw    = req.wr && (req.addr == A_RAW);
    wr_rawclr = req.wr && (req.addr == A_RAWCLR);
    wr_enset  = req.wr && (req.addr == A_ENSET);
    wr_enclr  = req.wr && (req.addr == A_ENCLR);
    wr_eoi    = req.wr && (req.addr == A_EOI);
    wr_reload = req.wr && (req.addr == A_RELOAD);
    sw_set    = wr_raw    && req.wdata[0];
    sw_clr    = wr_rawclr && req.wdata[0];
    en_set    = wr_enset  && req.wdata[0];
    en_clr    = wr_enclr  && req.wdata[0];
    ack       = wr_eoi    && (req.wdata[EOI_W-1:0] == '0);
  end

  // next state
  always_comb begin
    ctrl_n   = wr_ctrl   ? req.wdata[CTRL_HI:CTRL_LO] : ctrl_q;
    reload_n = wr_reload ? req.wdata[RELOAD_W-1:0]    : reload_q;
    set_evt  = sw_set || hw_wrap;
    if (set_evt)     raw_n = 1'b1;
    else if (sw_clr) raw_n = 1'b0;
    else             raw_n = raw_q;
    if (en_set)      en_n = 1'b1;
    else if (en_clr) en_n = 1'b0;
    else             en_n = en_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= CTRL_RST;
      reload_q <= '0;
      raw_q    <= 1'b0;
      en_q     <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_n;
      reload_q <= reload_n;
      raw_q    <= raw_n;
      en_q     <= en_n;
    end
  end

  // read path
  always_comb begin
    rdata = '0;
    case (req.addr)
      A_CTRL:   rdata[CTRL_HI:CTRL_LO] = ctrl_q;
      A_RAW:    rdata[0] = raw_q;
      A_ENSET:  rdata[0] = en_q;
      A_ENSTAT: rdata[0] = en_q;
      A_RELOAD: rdata[RELOAD_W-1:0] = reload_q;
      A_PEND:   rdata[PEND_W-1:0] = pend;
      default:  rdata = '0;
    endcase
  end

  assign run    = ctrl_q[CTRL_RUN];
  assign reload = reload_q;
  assign ovf_en = en_q;

endmodule

// File: rtl/ts_ovf_regs.sv
module ts_ovf_regs
  import ts_ovf_pkg::*;
#(
  parameter int TS_W     = 16,
  parameter int RELOAD_W = 24,
  parameter int PEND_W   = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [TS_W-1:0]   ts_value,
  output logic              ts_irq
);

  logic [1:0]          rst_sync_q;
  logic                rst_sync_n;
  bus_req_t            req;
  logic                run;
  logic [RELOAD_W-1:0] reload;
  logic                ovf_en;
  logic                set_evt;
  logic                ack;
  logic                hw_wrap;
  logic [PEND_W-1:0]   pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  assign req.wr    = bus_wr;
  assign req.addr  = bus_addr;
  assign req.wdata = bus_wdata;

  ts_regfile #(.RELOAD_W(RELOAD_W), .PEND_W(PEND_W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .req     (req),
    .rdata   (bus_rdata),
    .hw_wrap (hw_wrap),
    .pend    (pend),
    .run     (run),
    .reload  (reload),
    .ovf_en  (ovf_en),
    .set_evt (set_evt),
    .ack     (ack)
  );

  ts_counter #(.TS_W(TS_W), .RELOAD_W(RELOAD_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .run      (run),
    .reload   (reload),
    .ts       (ts_value),
    .wrap_evt (hw_wrap)
  );

  ts_pend_tracker #(.PEND_W(PEND_W)) u_pend (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_evt (set_evt),
    .ack     (ack),
    .ovf_en  (ovf_en),
    .pend    (pend),
    .irq     (ts_irq)
  );

endmodule

// File: rtl/ts_ovf_chk.sv
module ts_ovf_chk
  import ts_ovf_pkg::*;
#(
  parameter int TS_W   = 16,
  parameter int PEND_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [TS_W-1:0]   ts_value,
  input logic              ts_irq,
  input logic              run,
  input logic              ovf_en,
  input logic              set_evt,
  input logic              ack,
  input logic [PEND_W-1:0] pend
);

  localparam logic [PEND_W-1:0] PMAX = '1;
  localparam logic [PEND_W-1:0] PONE = PEND_W'(1);

  a_r3_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(ts_value));

  a_r6_clear_shadow_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_RAWCLR) |-> (bus_rdata == '0));

  a_r7_enclr_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ENCLR) |-> (bus_rdata == '0));

  a_r8_single_increment: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !ack && pend != PMAX) |=> (pend == PEND_W'($past(pend) + PONE)));

  a_r8_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    (set_evt && !ack && pend == PMAX) |=> (pend == PMAX));

  a_r9_floor_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set_evt && pend == '0) |=> (pend == '0));

  a_r9_reissue: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && ovf_en && pend > PONE) |=> ts_irq);

  a_r10_gated_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
    ts_irq |-> $past(ovf_en));

  a_r10_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    ts_irq |-> ($past(set_evt) || $past(ack)));

endmodule

bind ts_ovf_regs ts_ovf_chk #(.TS_W(TS_W), .PEND_W(PEND_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .bus_addr  (bus_addr),
  .bus_rdata (bus_rdata),
  .ts_value  (ts_value),
  .ts_irq    (ts_irq),
  .run       (run),
  .ovf_en    (ovf_en),
  .set_evt   (set_evt),
  .ack       (ack),
  .pend      (pend)
);

// File: tb/sim_ts_ovf_regs.sv
module sim_ts_ovf_regs;

  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] ts_value;
  logic        ts_irq;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  int irq_q[$];

  ts_ovf_regs u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .ts_value  (ts_value),
    .ts_irq    (ts_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // monitor: pops expected interrupt edges and compares
  always @(negedge clk) begin
    if (rst_n && ts_irq) begin
      n_tests++;
      if (irq_q.size() == 0) begin
        n_fail++;
        $display("FAIL R10 unexpected pulse actual=cycle %0d expected=none", cyc);
      end else begin
        int e;
        e = irq_q.pop_front();
        if (e != cyc) begin
          n_fail++;
          $display("FAIL R10 pulse actual=cycle %0d expected=cycle %0d", cyc, e);
        end
      end
    end
  end

  // driver: called on a falling edge, the write lands on the next rising edge
  task automatic wr_edge(input logic [3:0] a, input logic [31:0] d, input bit exp_irq,
                         output int edge_no);
    edge_no   = cyc + 1;
    if (exp_irq) irq_q.push_back(edge_no);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit exp_irq);
    int dummy;
    wr_edge(a, d, exp_irq, dummy);
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    check(req, bus_rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // watchdog
  initial begin
    #(20 * 190000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    int e_edge;
    int f_edge;
    bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    rd(4'h0, 32'h8, "R1 ctrl");
    rd(4'h1, 32'h0, "R1 raw");
    rd(4'h5, 32'h0, "R1 enstat");
    rd(4'h7, 32'h0, "R1 reload");
    rd(4'h8, 32'h0, "R1 pend");
    check("R1 ts", 32'(ts_value), 32'h0);
    check("R1 irq", 32'(ts_irq), 32'h0);

    // R2 reload 3
    wr(4'h7, 32'd3, 0);
    wr_edge(4'h0, 32'h48, 0, e_edge);
    check("R2 start", 32'(ts_value), 32'd0);
    idle(2);
    check("R2 before step", 32'(ts_value), 32'd0);
    idle(1);
    check("R2 step after 3", 32'(ts_value), 32'd1);

    // R3 stop holds
    wr(4'h0, 32'h8, 0);
    check("R3 after stop", 32'(ts_value), 32'd1);
    idle(10);
    check("R3 held", 32'(ts_value), 32'd1);

    // R2 reload 0 acts as 1, R4 wrap
    wr(4'h7, 32'd0, 0);
    wr(4'h3, 32'h1, 0);
    rd(4'h5, 32'h1, "R7 enable set");
    wr_edge(4'h0, 32'h48, 0, f_edge);
    irq_q.push_back(f_edge + 65535);
    check("R2 zero reload start", 32'(ts_value), 32'd1);
    idle(4);
    check("R2 zero reload every clock", 32'(ts_value), 32'd5);
    while (cyc < f_edge + 65535) @(negedge clk);
    check("R4 wrapped", 32'(ts_value), 32'd0);
    rd(4'h1, 32'h1, "R4 raw set by wrap");
    rd(4'h8, 32'd1, "R8 pend after wrap");
    wr(4'h0, 32'h8, 0);

    // R5 software set
    wr(4'h1, 32'h1, 1);
    wr(4'h1, 32'h1, 1);
    wr(4'h1, 32'h1, 1);
    rd(4'h8, 32'd4, "R8 pend after sw sets");
    wr(4'h1, 32'h0, 0);
    rd(4'h8, 32'd4, "R5 zero write no effect");
    rd(4'h1, 32'h1, "R5 raw");

    // R6 clear shadow
    rd(4'h2, 32'h0, "R6 shadow reads 0");
    wr(4'h2, 32'h1, 0);
    rd(4'h1, 32'h0, "R6 raw cleared");
    wr(4'h1, 32'h0, 0);
    rd(4'h1, 32'h0, "R5 zero write keeps clear");

    // R9 acknowledge
    wr(4'h6, 32'h05, 0);
    rd(4'h8, 32'd4, "R9 other value ignored");
    wr(4'h6, 32'h01, 0);
    rd(4'h8, 32'd4, "R9 value 1 no effect");
    wr(4'h6, 32'h00, 1);
    rd(4'h8, 32'd3, "R9 ack");
    wr(4'h6, 32'h00, 1);
    wr(4'h6, 32'h00, 1);
    rd(4'h8, 32'd1, "R9 ack twice");
    wr(4'h6, 32'h00, 0);
    rd(4'h8, 32'd0, "R9 last ack no pulse");
    wr(4'h6, 32'h00, 0);
    rd(4'h8, 32'd0, "R9 floor");

    // R7 enable clear, R10 gating
    wr(4'h4, 32'h1, 0);
    rd(4'h5, 32'h0, "R7 enstat cleared");
    rd(4'h4, 32'h0, "R7 enclr reads 0");
    wr(4'h1, 32'h1, 0);
    idle(2);
    rd(4'h8, 32'd1, "R10 counted without pulse");
    wr(4'h3, 32'h1, 0);
    rd(4'h5, 32'h1, "R7 enstat set");

    // R8 saturation
    for (int i = 0; i < 35; i++) wr(4'h1, 32'h1, 1);
    rd(4'h8, 32'd31, "R8 saturated");
    wr(4'h6, 32'h00, 1);
    rd(4'h8, 32'd30, "R9 ack from saturation");

    // R11 reserved bits
    wr(4'h0, 32'hFFFF_FFFF, 0);
    rd(4'h0, 32'h78, "R11 ctrl reserved");
    wr(4'h0, 32'h0, 0);
    rd(4'h0, 32'h0, "R11 ctrl cleared");
    wr(4'h7, 32'hFFFF_FFFF, 0);
    rd(4'h7, 32'h00FF_FFFF, "R11 reload width");
    rd(4'h6, 32'h0, "R11 eoi reads 0");
    rd(4'hF, 32'h0, "R11 unmapped");

    idle(4);
    check("R10 all pulses seen", 32'(irq_q.size()), 32'd0);
    finish_run();
  end

endmodule